// File: doc/BRIEF.md
# Interrupt Mask-Level Acceptance Controller

This block decides, once per clock, whether a processor takes a pending interrupt. It holds a two-bit mask level and a maskable-interrupt enable bit. It watches one non-maskable request and a set of maskable sources, each of which carries its own two-bit priority level. Level 0 is the most urgent priority. A maskable source passes only when its level is numerically below the current mask. The non-maskable request always passes.

On an acceptance the block emits a one-cycle pulse together with the winning source. It then tightens the mask to the accepted level, so that requests of equal or lower urgency are held off. The mask in force before the acceptance is pushed onto a four-entry internal stack. A return strobe pops that stack and restores the earlier mask. Software can also load the mask and the enable bit through a simple write port.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask level is 0, the enable bit is 0 and no accept pulse is driven, so only the non-maskable request can be taken.
- R2: With the enable bit at 1, a maskable source with its request bit set and level L (the 2-bit field at srcLvl[2i+1:2i] for source i) is accepted only when L < maskLevel. Mask 0 admits no maskable source, mask 1 admits level 0, mask 2 admits levels 0 to 1, and mask 3 admits levels 0 to 2.
- R3: With the enable bit at 0, no maskable source is accepted, whatever the mask level.
- R4: A non-maskable request is accepted at every mask level and with the enable bit at either value. It wins over any maskable request in the same cycle, drives acceptNmi=1 and acceptIdx=0, and forces the mask level to 0.
- R5: Accepting a maskable source of level L loads the mask level with L, one cycle after the decision, alongside the pulse.
- R6: An acceptance never changes the enable bit.
- R7: Among eligible maskable sources, the one with the numerically lowest level wins. Ties go to the lowest source index, which is reported on acceptIdx.
- R8: acceptPulse lasts a single cycle, and no acceptance occurs in the cycle that follows an accept, even if requests are still pending.
- R9: Each acceptance pushes the prior mask onto a 4-entry stack. When the stack is full, the oldest entry is discarded. A retStrobe pops the newest entry into the mask level. A pop of an empty stack leaves the mask unchanged. A retStrobe in a cycle with an acceptance is ignored.
- R10: A wrEn loads maskLevel from wrMask and the enable bit from wrEnable on the next edge. The whole write is ignored in a cycle with an acceptance or with a retStrobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiReq | input | 1 | Non-maskable interrupt request |
| srcReq | input | NUM_SRC | Maskable request bits, one per source |
| srcLvl | input | NUM_SRC*2 | Priority level of each source, 2 bits per source, source 0 in the low bits |
| retStrobe | input | 1 | Return from interrupt, restores the saved mask |
| wrEn | input | 1 | Software write of mask level and enable bit |
| wrMask | input | 2 | Mask level to write |
| wrEnable | input | 1 | Enable bit to write |
| acceptPulse | output | 1 | One-cycle pulse for an accepted interrupt |
| acceptNmi | output | 1 | The accepted interrupt is the non-maskable one |
| acceptIdx | output | $clog2(NUM_SRC) | Index of the accepted maskable source |
| maskLevel | output | 2 | Current mask level |
| intEnable | output | 1 | Current maskable-interrupt enable bit |

## Verification
A wrong mask register shows up on the very next cycle at the maskLevel output. It also shows up as a missed or spurious acceptance when a request at the boundary level is applied. A corrupted save stack stays hidden until a return strobe restores a value that differs from the mask that was saved. The bench therefore nests three acceptances, unwinds them, and overflows the stack to expose ordering faults. Arbitration faults appear as a wrong acceptIdx in the cycle after the decision.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int LVL_W = 2;

  typedef struct packed {
    logic             push;
    logic             pop;
    logic             loadWrite;
    logic [LVL_W-1:0] newLevel;
  } ctrlStrobesT;
endpackage

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_mask_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       srcReq,
  input  logic [NUM_SRC*LVL_W-1:0] srcLvl,
  input  logic [LVL_W-1:0]         maskLevel,
  input  logic                     intEnable,
  output logic                     found,
  output logic [IDX_W-1:0]         bestIdx,
  output logic [LVL_W-1:0]         bestLvl
);
  logic [NUM_SRC-1:0] eligible;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign eligible[i] = srcReq[i] && intEnable &&
                         (srcLvl[i*LVL_W +: LVL_W] < maskLevel);
  end

  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestLvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!found || srcLvl[i*LVL_W +: LVL_W] < bestLvl)) begin
        found   = 1'b1;
        bestIdx = IDX_W'(i);
        bestLvl = srcLvl[i*LVL_W +: LVL_W];
      end
    end
  end

  AST_PICK_REQUESTED: assert property (@(posedge clk) disable iff (!rstN)
    found |-> (srcReq[bestIdx] && intEnable)); // R3
  AST_PICK_BELOW_MASK: assert property (@(posedge clk) disable iff (!rstN)
    found |-> (bestLvl < maskLevel)); // R2
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_mask_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     nmiReq,
  input  logic [NUM_SRC-1:0]       srcReq,
  input  logic [NUM_SRC*LVL_W-1:0] srcLvl,
  input  logic                     retStrobe,
  input  logic                     wrEn,
  input  logic [LVL_W-1:0]         maskLevel,
  input  logic                     intEnable,
  output ctrlStrobesT              strobes,
  output logic                     acceptPulse,
  output logic                     acceptNmi,
  output logic [IDX_W-1:0]         acceptIdx
);
  logic             found;
  logic [IDX_W-1:0] bestIdx;
  logic [LVL_W-1:0] bestLvl;
  logic             takeNmi;
  logic             takeMask;
  logic             takeAny;

  irq_level_arbiter #(.NUM_SRC(NUM_SRC)) uArb (
    .clk       (clk),
    .rstN      (rstN),
    .srcReq    (srcReq),
    .srcLvl    (srcLvl),
    .maskLevel (maskLevel),
    .intEnable (intEnable),
    .found     (found),
    .bestIdx   (bestIdx),
    .bestLvl   (bestLvl)
  );

  // The cycle after an accept is a dead cycle for the handler entry.
  assign takeNmi  = nmiReq && !acceptPulse;
  assign takeMask = found && !acceptPulse && !nmiReq;
  assign takeAny  = takeNmi || takeMask;

  always_comb begin
    strobes.push      = takeAny;
    strobes.pop       = retStrobe && !takeAny;
    strobes.loadWrite = wrEn && !takeAny && !retStrobe;
    strobes.newLevel  = takeNmi ? '0 : bestLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptPulse <= 1'b0;
      acceptNmi   <= 1'b0;
      acceptIdx   <= '0;
    end else begin
      acceptPulse <= takeAny;
      acceptNmi   <= takeNmi;
      acceptIdx   <= takeMask ? bestIdx : '0;
    end
  end

  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |=> !acceptPulse); // R8
  AST_MASKABLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (acceptPulse && !acceptNmi) |-> $past(intEnable)); // R3
  AST_MASK_TIGHTENS: assert property (@(posedge clk) disable iff (!rstN)
    (acceptPulse && !acceptNmi) |-> (maskLevel < $past(maskLevel))); // R5
  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (nmiReq && !acceptPulse) |=> (acceptPulse && acceptNmi)); // R4
endmodule

// File: rtl/irq_mask_datapath.sv
module irq_mask_datapath
  import irq_mask_pkg::*;
#(
  parameter int STACK_DEPTH = 4,
  localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobesT      strobes,
  input  logic [LVL_W-1:0] wrMask,
  input  logic             wrEnable,
  output logic [LVL_W-1:0] maskLevel,
  output logic             intEnable
);
  logic [LVL_W-1:0] stackMem [STACK_DEPTH];
  logic [CNT_W-1:0] stackCnt;
  logic             stackEmpty;

  assign stackEmpty = (stackCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskLevel <= '0;
      intEnable <= 1'b0;
      stackCnt  <= '0;
      for (int k = 0; k < STACK_DEPTH; k++) stackMem[k] <= '0;
    end else if (strobes.push) begin
      maskLevel   <= strobes.newLevel;
      stackMem[0] <= maskLevel;
      for (int k = 1; k < STACK_DEPTH; k++) stackMem[k] <= stackMem[k-1];
      if (stackCnt != CNT_W'(STACK_DEPTH)) stackCnt <= stackCnt + 1'b1;
    end else if (strobes.pop) begin
      if (!stackEmpty) begin
        maskLevel <= stackMem[0];
        for (int k = 0; k < STACK_DEPTH - 1; k++) stackMem[k] <= stackMem[k+1];
        stackMem[STACK_DEPTH-1] <= '0;
        stackCnt <= stackCnt - 1'b1;
      end
    end else if (strobes.loadWrite) begin
      maskLevel <= wrMask;
      intEnable <= wrEnable;
    end
  end

  AST_EN_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |=> (intEnable == $past(intEnable))); // R6
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pop && stackEmpty) |=> $stable(maskLevel)); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stackCnt <= CNT_W'(STACK_DEPTH)); // R9
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int STACK_DEPTH = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     nmiReq,
  input  logic [NUM_SRC-1:0]       srcReq,
  input  logic [NUM_SRC*LVL_W-1:0] srcLvl,
  input  logic                     retStrobe,
  input  logic                     wrEn,
  input  logic [LVL_W-1:0]         wrMask,
  input  logic                     wrEnable,
  output logic                     acceptPulse,
  output logic                     acceptNmi,
  output logic [IDX_W-1:0]         acceptIdx,
  output logic [LVL_W-1:0]         maskLevel,
  output logic                     intEnable
);
  ctrlStrobesT strobes;

  irq_accept_ctrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .nmiReq      (nmiReq),
    .srcReq      (srcReq),
    .srcLvl      (srcLvl),
    .retStrobe   (retStrobe),
    .wrEn        (wrEn),
    .maskLevel   (maskLevel),
    .intEnable   (intEnable),
    .strobes     (strobes),
    .acceptPulse (acceptPulse),
    .acceptNmi   (acceptNmi),
    .acceptIdx   (acceptIdx)
  );

  irq_mask_datapath #(.STACK_DEPTH(STACK_DEPTH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrMask    (wrMask),
    .wrEnable  (wrEnable),
    .maskLevel (maskLevel),
    .intEnable (intEnable)
  );
endmodule

// File: tb/irq_mask_ctrl_test.sv
`timescale 1ns/1ps
module irq_mask_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       nmiReq = 1'b0;
  logic [3:0] srcReq = '0;
  logic [7:0] srcLvl = '0;
  logic       retStrobe = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrMask = '0;
  logic       wrEnable = 1'b0;
  logic       acceptPulse, acceptNmi;
  logic [1:0] acceptIdx, maskLevel;
  logic       intEnable;
  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_mask_ctrl uut (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .srcReq(srcReq), .srcLvl(srcLvl),
    .retStrobe(retStrobe), .wrEn(wrEn), .wrMask(wrMask), .wrEnable(wrEnable),
    .acceptPulse(acceptPulse), .acceptNmi(acceptNmi), .acceptIdx(acceptIdx),
    .maskLevel(maskLevel), .intEnable(intEnable)
  );

  typedef struct packed {
    logic [1:0] mask;
    logic       en;
    logic [3:0] req;
    logic [7:0] lvl;
    logic       nmi;
    logic       expAcc;
    logic       expNmi;
    logic [1:0] expIdx;
    logic [1:0] expMask;
  } vecT;

  localparam int NVEC = 11;
  localparam vecT VEC [NVEC] = '{
    '{2'd3, 1'b1, 4'b0001, 8'b00_00_00_10, 1'b0, 1'b1, 1'b0, 2'd0, 2'd2}, // R2 level 2 under mask 3
    '{2'd2, 1'b1, 4'b0001, 8'b00_00_00_10, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2}, // R2 equal level refused
    '{2'd0, 1'b1, 4'b1111, 8'b00_00_00_00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R2 mask 0 blocks all
    '{2'd1, 1'b1, 4'b0100, 8'b11_00_11_11, 1'b0, 1'b1, 1'b0, 2'd2, 2'd0}, // R5 level 0 under mask 1
    '{2'd3, 1'b0, 4'b1111, 8'b00_00_00_00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3}, // R3 disabled
    '{2'd3, 1'b1, 4'b1110, 8'b00_00_01_00, 1'b0, 1'b1, 1'b0, 2'd2, 2'd0}, // R7 lowest level
    '{2'd3, 1'b1, 4'b0011, 8'b00_00_01_01, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1}, // R7 tie low index
    '{2'd0, 1'b0, 4'b0000, 8'b00_00_00_00, 1'b1, 1'b1, 1'b1, 2'd0, 2'd0}, // R4 nmi at mask 0, en 0
    '{2'd3, 1'b1, 4'b0001, 8'b00_00_00_00, 1'b1, 1'b1, 1'b1, 2'd0, 2'd0}, // R4 nmi beats maskable
    '{2'd2, 1'b1, 4'b1000, 8'b01_00_00_00, 1'b0, 1'b1, 1'b0, 2'd3, 2'd1}, // R5 level 1 under mask 2
    '{2'd3, 1'b1, 4'b0000, 8'b00_00_00_00, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3}  // R2 no request
  };

  task automatic check(string tag, logic expAcc, logic expNmi, logic [1:0] expIdx,
                       logic [1:0] expMask, logic expEn);
    total++;
    if (acceptPulse !== expAcc || acceptNmi !== expNmi || acceptIdx !== expIdx ||
        maskLevel !== expMask || intEnable !== expEn) begin
      bad++;
      $display("FAIL %s: acc=%0b nmi=%0b idx=%0d mask=%0d en=%0b expected acc=%0b nmi=%0b idx=%0d mask=%0d en=%0b",
               tag, acceptPulse, acceptNmi, acceptIdx, maskLevel, intEnable,
               expAcc, expNmi, expIdx, expMask, expEn);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    nmiReq = 0; srcReq = '0; retStrobe = 0; wrEn = 0;
    tick();
  endtask

  task automatic writeReg(logic [1:0] m, logic e);
    @(negedge clk);
    nmiReq = 0; srcReq = '0; retStrobe = 0;
    wrEn = 1; wrMask = m; wrEnable = e;
    tick();
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    nmiReq = 0; srcReq = '0; retStrobe = 0; wrEn = 0;
    rstN = 0;
    tick(); tick();
    @(negedge clk);
    rstN = 1;
    tick();
  endtask

  task automatic popCheck(string tag, logic [1:0] expMask, logic expEn);
    @(negedge clk);
    retStrobe = 1;
    tick();
    check(tag, 0, 0, 0, expMask, expEn);
    @(negedge clk);
    retStrobe = 0;
  endtask

  task automatic nmiOnce(logic [1:0] expMask, logic expEn);
    @(negedge clk);
    nmiReq = 1;
    tick();
    check("R4 nmi push", 1, 1, 0, expMask, expEn);
    idle();
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: acc=%0b expected run to finish", acceptPulse);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    check("R1 reset", 0, 0, 0, 0, 0);
    @(negedge clk);
    rstN = 1;
    srcReq = 4'b1111; srcLvl = 8'h00;
    tick();
    check("R1 maskable refused after reset", 0, 0, 0, 0, 0);
    idle();

    for (int v = 0; v < NVEC; v++) begin
      writeReg(VEC[v].mask, VEC[v].en);
      @(negedge clk);
      srcReq = VEC[v].req; srcLvl = VEC[v].lvl; nmiReq = VEC[v].nmi;
      tick();
      check($sformatf("R2 vector %0d", v), VEC[v].expAcc, VEC[v].expNmi,
            VEC[v].expIdx, VEC[v].expMask, VEC[v].en);
      idle();
      check($sformatf("R8 vector %0d idle", v), 0, 0, 0, VEC[v].expMask, VEC[v].en);
    end

    // R8: a held request is refused in the cycle after an accept
    doReset();
    @(negedge clk);
    nmiReq = 1;
    tick();
    check("R8 first accept", 1, 1, 0, 0, 0);
    tick();
    check("R8 dead cycle", 0, 0, 0, 0, 0);
    tick();
    check("R8 accept again", 1, 1, 0, 0, 0);
    idle();

    // R9: nested accepts unwound by returns
    doReset();
    writeReg(2'd3, 1'b1);
    @(negedge clk); srcReq = 4'b0001; srcLvl = 8'b00_00_00_10; tick();
    check("R9 nest 1", 1, 0, 0, 2, 1);
    idle();
    @(negedge clk); srcReq = 4'b0010; srcLvl = 8'b00_00_01_00; tick();
    check("R9 nest 2", 1, 0, 1, 1, 1);
    idle();
    @(negedge clk); srcReq = 4'b0100; srcLvl = 8'b00_00_00_00; tick();
    check("R9 nest 3", 1, 0, 2, 0, 1);
    idle();
    popCheck("R9 pop to 1", 1, 1);
    popCheck("R9 pop to 2", 2, 1);
    popCheck("R9 pop to 3", 3, 1);
    popCheck("R9 empty pop holds", 3, 1);

    // R9: overflow drops the oldest saved mask
    doReset();
    writeReg(2'd3, 1'b0); nmiOnce(0, 0);
    writeReg(2'd2, 1'b0); nmiOnce(0, 0);
    writeReg(2'd1, 1'b0); nmiOnce(0, 0);
    writeReg(2'd3, 1'b0); nmiOnce(0, 0);
    writeReg(2'd2, 1'b0); nmiOnce(0, 0);
    popCheck("R9 overflow pop 1", 2, 0);
    popCheck("R9 overflow pop 2", 3, 0);
    popCheck("R9 overflow pop 3", 1, 0);
    popCheck("R9 overflow pop 4", 2, 0);
    popCheck("R9 overflow empty", 2, 0);

    // R10: write loses to accept; R9: return ignored during accept
    doReset();
    writeReg(2'd3, 1'b1);
    check("R10 write applied", 0, 0, 0, 3, 1);
    @(negedge clk);
    srcReq = 4'b0001; srcLvl = 8'b00_00_00_10;
    wrEn = 1; wrMask = 2'd1; wrEnable = 1'b0; retStrobe = 1;
    tick();
    check("R10 write lost to accept", 1, 0, 0, 2, 1);
    idle();
    check("R6 enable kept", 0, 0, 0, 2, 1);
    popCheck("R9 stack kept one entry", 3, 1);
    popCheck("R9 stack now empty", 3, 1);

    // R10: write ignored alongside a return
    @(negedge clk); nmiReq = 1; tick();
    check("R4 nmi push from 3", 1, 1, 0, 0, 1);
    idle();
    @(negedge clk);
    retStrobe = 1; wrEn = 1; wrMask = 2'd2; wrEnable = 1'b0;
    tick();
    check("R10 write lost to return", 0, 0, 0, 3, 1);
    idle();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule